// File: doc/BRIEF.md
# Receive Flow Control and Idle Timeout

This block sits beside a serial receiver and its receive buffer. From the buffer's current byte count it drives the request-to-send line back to the far transmitter. The line goes high ("stop sending") once the buffer holds more bytes than a high watermark. It returns low ("ready") only after the count drops below a low watermark. Between the two marks the line keeps its last state. Software can override the line with a force bit and a value bit.

The block also measures how long the line has been idle since the last completed character. A bit-time counter starts when the receiver reports a received stop bit and advances on each bit-time tick. A new start bit halts it and clears it. The counter saturates instead of wrapping. When it reaches a programmable limit while unread bytes are waiting, a timeout flag rises. The host can then collect a short trailing message that never crossed a watermark.

All inputs are plain control and status levels or single-cycle strobes from the neighbouring receiver, buffer and register blocks. No data stream passes through, so there is no valid/ready handshake. The watermark, force and limit values come from the register block. Their reset values are a high mark of 0xFF, a low mark of 0x00, a limit of 0x00 and force/value bits of 0.

Top module: `rx_flow_timeout`

## Requirements
- R1: With force off, if the byte count is greater than the high mark at a clock edge, `rts` is 1 after that edge.
- R2: With force off, if the byte count is less than the low mark and not greater than the high mark at a clock edge, `rts` is 0 after that edge.
- R3: With force off, a count that is neither above the high mark nor below the low mark (equality with either mark included) leaves `rts` unchanged.
- R4: With force on at a clock edge, `rts` equals the force value bit after that edge (1 drives high, 0 drives low). The watermark state keeps tracking while forced, and it takes over again once force is released.
- R5: `rx_high` is 1 exactly while the byte count is greater than the high mark, without delay.
- R6: After reset, `rts` and `rx_timeout` are 0, and the idle timer is stopped at zero. Ticks arriving before the first stop-bit strobe do not advance it.
- R7: A stop-bit strobe clears the idle count and starts it. Each bit tick afterwards adds one. One edge after the count is at or above the limit while the byte count is nonzero, `rx_timeout` is 1. A limit of 0 raises the flag one edge after the stop strobe.
- R8: The idle count saturates at 255 and never wraps, so a limit of 255 is reached and held after many ticks.
- R9: A byte count of zero at a clock edge makes `rx_timeout` 0 after that edge.
- R10: A start-bit strobe at a clock edge clears the idle count, stops the timer until the next stop strobe, and makes `rx_timeout` 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fill_count | input | CNT_W | Current receive-buffer byte count |
| mark_high | input | MARK_W | High watermark |
| mark_low | input | MARK_W | Low watermark |
| force_en | input | 1 | 1: `rts` follows `force_val` |
| force_val | input | 1 | Level driven on `rts` while forced |
| start_seen | input | 1 | One-cycle strobe: start bit detected |
| stop_seen | input | 1 | One-cycle strobe: stop bit received |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| idle_limit | input | TMO_W | Idle timeout in bit times (0 to 255) |
| rts | output | 1 | Request-to-send, 1 = not ready |
| rx_high | output | 1 | Byte count above high mark |
| rx_timeout | output | 1 | Idle limit reached with bytes waiting |

## Verification
The assertions assume that the low mark is configured at or below the high mark. They also assume that the start and stop strobes come from one receiver and so never pulse in the same cycle. The R2 property encodes the first assumption in its antecedent, and the timer properties exclude simultaneous strobes. The bench drives only single-cycle strobes with idle cycles between them, and it programs marks with low below high. It changes inputs on the falling clock edge, so every property sees stable values at the rising edge.

// File: rtl/rx_flow_timeout_pkg.sv
package rx_flow_timeout_pkg;
  typedef enum logic {
    TMR_HALT = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/rxfc_rts_ctrl.sv
module rxfc_rts_ctrl #(
  parameter int CNT_W  = 5,
  parameter int MARK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fill_count,
  input  logic [MARK_W-1:0] mark_high,
  input  logic [MARK_W-1:0] mark_low,
  input  logic              force_en,
  input  logic              force_val,
  output logic              rts,
  output logic              above_high
);
  localparam int CW = (CNT_W > MARK_W) ? CNT_W : MARK_W;

  logic [CW-1:0] fill_x, high_x, low_x;
  logic          below_low;
  logic          auto_q, auto_d;

  assign fill_x     = CW'(fill_count);
  assign high_x     = CW'(mark_high);
  assign low_x      = CW'(mark_low);
  assign above_high = fill_x > high_x;
  assign below_low  = fill_x < low_x;

  // hysteresis: high mark wins if both conditions hold
  always_comb begin
    auto_d = auto_q;
    if (above_high)     auto_d = 1'b1;
    else if (below_low) auto_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q <= 1'b0;
      rts    <= 1'b0;
    end else begin
      auto_q <= auto_d;
      rts    <= force_en ? force_val : auto_d;
    end
  end
endmodule

// File: rtl/rxfc_idle_timer.sv
module rxfc_idle_timer
  import rx_flow_timeout_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_seen,
  input  logic             stop_seen,
  input  logic             bit_tick,
  output logic [TMO_W-1:0] elapsed,
  output logic             running
);
  localparam logic [TMO_W-1:0] TOP = '1;

  tmr_state_e state_q;

  assign running = (state_q == TMR_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TMR_HALT;
      elapsed <= '0;
    end else if (start_seen) begin
      state_q <= TMR_HALT;
      elapsed <= '0;
    end else if (stop_seen) begin
      state_q <= TMR_RUN;
      elapsed <= '0;
    end else if (running && bit_tick && elapsed != TOP) begin
      elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/rxfc_tmo_flag.sv
module rxfc_tmo_flag #(
  parameter int CNT_W = 5,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill_count,
  input  logic [TMO_W-1:0] elapsed,
  input  logic             running,
  input  logic [TMO_W-1:0] idle_limit,
  input  logic             start_seen,
  output logic             rx_timeout
);
  logic reached;
  assign reached = running && (elapsed >= idle_limit);

  always_ff @(posedge clk) begin
    if (rst) rx_timeout <= 1'b0;
    else     rx_timeout <= reached && (fill_count != '0) && !start_seen;
  end
endmodule

// File: rtl/rx_flow_timeout.sv
module rx_flow_timeout #(
  parameter int CNT_W  = 5,
  parameter int MARK_W = 8,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fill_count,
  input  logic [MARK_W-1:0] mark_high,
  input  logic [MARK_W-1:0] mark_low,
  input  logic              force_en,
  input  logic              force_val,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              bit_tick,
  input  logic [TMO_W-1:0]  idle_limit,
  output logic              rts,
  output logic              rx_high,
  output logic              rx_timeout
);
  logic [TMO_W-1:0] idle_cnt;
  logic             idle_run;

  rxfc_rts_ctrl #(.CNT_W(CNT_W), .MARK_W(MARK_W)) u_rts (
    .clk(clk), .rst(rst), .fill_count(fill_count),
    .mark_high(mark_high), .mark_low(mark_low),
    .force_en(force_en), .force_val(force_val),
    .rts(rts), .above_high(rx_high)
  );

  rxfc_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .start_seen(start_seen), .stop_seen(stop_seen),
    .bit_tick(bit_tick), .elapsed(idle_cnt), .running(idle_run)
  );

  rxfc_tmo_flag #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_flag (
    .clk(clk), .rst(rst), .fill_count(fill_count), .elapsed(idle_cnt),
    .running(idle_run), .idle_limit(idle_limit), .start_seen(start_seen),
    .rx_timeout(rx_timeout)
  );
endmodule

// File: rtl/rx_flow_timeout_checks.sv
module rx_flow_timeout_checks #(
  parameter int CNT_W  = 5,
  parameter int MARK_W = 8,
  parameter int TMO_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  fill_count,
  input logic [MARK_W-1:0] mark_high,
  input logic [MARK_W-1:0] mark_low,
  input logic              force_en,
  input logic              force_val,
  input logic              start_seen,
  input logic              stop_seen,
  input logic              rts,
  input logic              rx_high,
  input logic              rx_timeout,
  input logic [TMO_W-1:0]  idle_cnt
);
  localparam int CW = (CNT_W > MARK_W) ? CNT_W : MARK_W;
  localparam logic [TMO_W-1:0] TOP = '1;

  logic [CW-1:0] f, h, l;
  assign f = CW'(fill_count);
  assign h = CW'(mark_high);
  assign l = CW'(mark_low);

  a_r1_rise_above_high: assert property (@(posedge clk) disable iff (rst)
    (!force_en && f > h) |=> rts);

  a_r2_fall_below_low: assert property (@(posedge clk) disable iff (rst)
    (!force_en && f < l && !(f > h)) |=> !rts);

  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!force_en && !$past(force_en) && !(f > h) && !(f < l)) |=> (rts == $past(rts)));

  a_r4_force_level: assert property (@(posedge clk) disable iff (rst)
    force_en |=> (rts == $past(force_val)));

  a_r5_high_flag: assert property (@(posedge clk) disable iff (rst)
    rx_high == (f > h));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt == TOP && !start_seen && !stop_seen) |=> (idle_cnt == TOP));

  a_r9_empty_clears: assert property (@(posedge clk) disable iff (rst)
    (fill_count == '0) |=> !rx_timeout);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> (!rx_timeout && idle_cnt == '0));
endmodule

bind rx_flow_timeout rx_flow_timeout_checks #(
  .CNT_W(CNT_W), .MARK_W(MARK_W), .TMO_W(TMO_W)
) u_checks (
  .clk(clk), .rst(rst), .fill_count(fill_count), .mark_high(mark_high),
  .mark_low(mark_low), .force_en(force_en), .force_val(force_val),
  .start_seen(start_seen), .stop_seen(stop_seen), .rts(rts),
  .rx_high(rx_high), .rx_timeout(rx_timeout), .idle_cnt(idle_cnt)
);

// File: tb/test_rx_flow_timeout.sv
module test_rx_flow_timeout;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] fill_count;
  logic [7:0] mark_high, mark_low, idle_limit;
  logic       force_en, force_val, start_seen, stop_seen, bit_tick;
  logic       rts, rx_high, rx_timeout;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2ns clk = ~clk;

  rx_flow_timeout i_rx_flow_timeout (
    .clk(clk), .rst(rst), .fill_count(fill_count), .mark_high(mark_high),
    .mark_low(mark_low), .force_en(force_en), .force_val(force_val),
    .start_seen(start_seen), .stop_seen(stop_seen), .bit_tick(bit_tick),
    .idle_limit(idle_limit), .rts(rts), .rx_high(rx_high),
    .rx_timeout(rx_timeout)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // advance n rising edges; inputs change and outputs are sampled at negedge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_stop();  stop_seen = 1'b1;  step(1); stop_seen = 1'b0;  endtask
  task automatic pulse_start(); start_seen = 1'b1; step(1); start_seen = 1'b0; endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1'b1; step(1); bit_tick = 1'b0; step(1); end
  endtask

  task automatic t_reset();
    rst = 1'b1; fill_count = '0; mark_high = 8'hFF; mark_low = 8'h00;
    idle_limit = 8'h00; force_en = 1'b0; force_val = 1'b0;
    start_seen = 1'b0; stop_seen = 1'b0; bit_tick = 1'b0;
    step(3); rst = 1'b0; step(1);
    check("R6", "rts after reset", rts, 1'b0);
    check("R6", "rx_timeout after reset", rx_timeout, 1'b0);
    check("R5", "rx_high after reset", rx_high, 1'b0);
    // timer halted: ticks before any stop strobe do not count (limit 1)
    fill_count = 5'd2; idle_limit = 8'd1;
    ticks(4); step(1);
    check("R6", "no timeout before first stop", rx_timeout, 1'b0);
    fill_count = '0; step(1);
  endtask

  task automatic t_hysteresis();
    mark_high = 8'd10; mark_low = 8'd4;
    fill_count = 5'd11; #0.1ns;
    check("R5", "rx_high immediate above", rx_high, 1'b1);
    step(1);
    check("R1", "rts high above mark", rts, 1'b1);
    fill_count = 5'd7; step(1);
    check("R3", "rts held between marks", rts, 1'b1);
    check("R5", "rx_high low between", rx_high, 1'b0);
    fill_count = 5'd4; step(1);
    check("R3", "rts held at low mark", rts, 1'b1);
    fill_count = 5'd3; step(1);
    check("R2", "rts low below mark", rts, 1'b0);
    fill_count = 5'd10; step(1);
    check("R3", "rts held at high mark", rts, 1'b0);
    check("R5", "rx_high at equal mark", rx_high, 1'b0);
  endtask

  task automatic t_force();
    fill_count = 5'd0; force_en = 1'b1; force_val = 1'b1; step(1);
    check("R4", "forced high", rts, 1'b1);
    fill_count = 5'd12; force_val = 1'b0; step(1);
    check("R4", "forced low above mark", rts, 1'b0);
    force_en = 1'b0; step(1);
    check("R4", "release returns tracked state", rts, 1'b1);
    fill_count = 5'd0; step(1);
    check("R2", "rts low after drain", rts, 1'b0);
  endtask

  task automatic t_timeout();
    fill_count = 5'd2; idle_limit = 8'd3;
    pulse_stop();
    ticks(2); step(1);
    check("R7", "below limit", rx_timeout, 1'b0);
    ticks(1); step(1);
    check("R7", "limit reached", rx_timeout, 1'b1);
    fill_count = 5'd0; step(1);
    check("R9", "empty clears flag", rx_timeout, 1'b0);
    fill_count = 5'd2; step(1);
    check("R7", "flag returns with data", rx_timeout, 1'b1);
    pulse_start();
    check("R10", "start clears flag", rx_timeout, 1'b0);
    ticks(6); step(1);
    check("R10", "timer halted after start", rx_timeout, 1'b0);
    idle_limit = 8'd0;
    pulse_stop(); step(1);
    check("R7", "zero limit right after stop", rx_timeout, 1'b1);
  endtask

  task automatic t_saturate();
    idle_limit = 8'd255; fill_count = 5'd1;
    pulse_start();
    pulse_stop();
    ticks(254); step(1);
    check("R8", "one short of 255", rx_timeout, 1'b0);
    ticks(50); step(1);
    check("R8", "held at 255 no wrap", rx_timeout, 1'b1);
  endtask

  initial begin
    t_reset();
    t_hysteresis();
    t_force();
    t_timeout();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule